// File: doc/BRIEF.md
# Packet Directory Scanner

After reset this block walks a word array that is laid out as a chain of variable-length packets. Each packet begins with a header word whose size field gives the payload length in words. The block reads each header through a synchronous read port. It records the word position of that header as the start of the next packet ID, and then jumps straight to the following header. Because the start of each packet depends on the sizes of all the packets before it, the resulting directory cannot be computed from a fixed stride.

While it walks, the block also keeps the number of packets found and a running count of the bytes they occupy. The walk stops in any of these cases:
- a header has a zero size;
- the byte count reaches its limit;
- the next header would lie beyond the array;
- the directory is full and a further packet turns up.

Once the walk has finished, a lookup port turns a packet ID into its starting word offset, together with a hit flag. Lookups are plain control signals with one cycle of latency. They have no handshake, and a new ID may be presented every cycle.

Top module: `pkt_dir_scan`

## Requirements
- R1: After reset the walk begins by reading word 0. Packets found are numbered 0, 1, 2, … in walk order, and each directory entry holds the word position of that packet's header.
- R2: Only header bits 15:8 form the size field. All other header bits have no effect on offsets, count or byte total.
- R3: After a packet with size field S at position P, the next header is read at position P + S + 2.
- R4: Each packet found adds 4 × (S + 1) to the byte total. The total stays constant once the walk ends.
- R5: A header with a zero size field ends the walk. It is not counted, and no later header is read.
- R6: The walk ends as soon as the byte total, including the packet just counted, is at least 11264.
- R7: The walk ends without a read when the next header position would be at or beyond ARRAY_WORDS (2816). Every read address is below ARRAY_WORDS.
- R8: The directory holds 64 entries. A nonzero header found while it is full is not counted: the overflow flag sets and the walk ends with the count at 64.
- R9: A lookup ID presented in one cycle is answered in the next cycle. The hit flag is high only when the walk is done and ID < packet count. On a miss the offset reads 0.
- R10: Any lookup sampled while the walk is not yet done misses. This includes a lookup sampled in the cycle the walk finishes.
- R11: The done flag rises once, when the walk ends, and stays high until reset. Reset clears done, count, byte total, overflow and the hit flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the walk restarts on release |
| rom_rd_o | output | 1 | Read strobe to the word array |
| rom_addr_o | output | 12 | Word address of the header being read |
| rom_data_i | input | 32 | Word returned one cycle after the strobe |
| lk_id_i | input | 7 | Packet ID to look up |
| lk_hit_o | output | 1 | Lookup hit, one cycle after the ID |
| lk_off_o | output | 12 | Start word offset of the looked-up packet (0 on a miss) |
| pkt_count_o | output | 7 | Number of packets found |
| byte_total_o | output | 14 | Bytes occupied by the packets found |
| done_o | output | 1 | Walk finished |
| overflow_o | output | 1 | A packet was found while the directory was full |

## Verification
Two pairs of events can fall in the same cycle, and both are provoked.

The first pair is a lookup and the end of the walk. The ID input is held at 0 throughout every walk. The bench then checks that the answer registered in the cycle where done rises is still a miss, and that the answer one cycle later is a hit whenever packets exist.

The second pair is the byte-limit stop and the array-end stop. An image of eleven maximum-size packets reaches 11264 bytes in the same evaluation in which the next position passes the array end. The bench judges this case by the count, the total and the absence of any out-of-range read. A neighbouring image of eleven packets one word shorter isolates the array-end stop below the byte limit.

// File: rtl/pkt_dir_pkg.sv
package pkt_dir_pkg;
  typedef enum logic [1:0] {
    SC_ISSUE = 2'd0,
    SC_EVAL  = 2'd1,
    SC_DONE  = 2'd2
  } scan_state_e;
endpackage

// File: rtl/pds_walker.sv
module pds_walker
  import pkt_dir_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int ARRAY_WORDS = 2816,
  parameter int BYTE_LIMIT  = 11264,
  parameter int DIR_DEPTH   = 64,
  parameter int SIZE_LSB    = 8,
  parameter int SIZE_W      = 8,
  localparam int AW = $clog2(ARRAY_WORDS),
  localparam int BW = $clog2(BYTE_LIMIT + 4 * (1 << SIZE_W) + 1),
  localparam int CW = $clog2(DIR_DEPTH + 1),
  localparam int IW = $clog2(DIR_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              rom_rd,
  output logic [AW-1:0]     rom_addr,
  input  logic [WORD_W-1:0] rom_data,
  output logic              wr_en,
  output logic [IW-1:0]     wr_idx,
  output logic [AW-1:0]     wr_off,
  output logic [CW-1:0]     count,
  output logic [BW-1:0]     bytes,
  output logic              done,
  output logic              overflow
);
  localparam int PW = $clog2(ARRAY_WORDS + (1 << SIZE_W) + 3);

  scan_state_e       state_q, state_d;
  logic [AW-1:0]     pos_q, pos_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BW-1:0]     bytes_q, bytes_d, bytes_sum;
  logic              ovf_q, ovf_d;
  logic [SIZE_W-1:0] size;
  logic [PW-1:0]     nxt_pos;
  logic              hdr_unused;

  assign size       = rom_data[SIZE_LSB +: SIZE_W];
  assign hdr_unused = ^{rom_data[WORD_W-1:SIZE_LSB+SIZE_W], rom_data[SIZE_LSB-1:0]};
  assign nxt_pos    = PW'(pos_q) + PW'(size) + PW'(2);
  assign bytes_sum  = bytes_q + BW'((BW'(size) + BW'(1)) << 2);

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    cnt_d   = cnt_q;
    bytes_d = bytes_q;
    ovf_d   = ovf_q;
    wr_en   = 1'b0;
    case (state_q)
      SC_ISSUE: state_d = SC_EVAL;
      SC_EVAL: begin
        if (size == '0) begin
          state_d = SC_DONE;
        end else if (cnt_q == CW'(DIR_DEPTH)) begin
          ovf_d   = 1'b1;
          state_d = SC_DONE;
        end else begin
          wr_en   = 1'b1;
          cnt_d   = cnt_q + CW'(1);
          bytes_d = bytes_sum;
          if (bytes_sum >= BW'(BYTE_LIMIT) || nxt_pos >= PW'(ARRAY_WORDS)) begin
            state_d = SC_DONE;
          end else begin
            pos_d   = nxt_pos[AW-1:0];
            state_d = SC_ISSUE;
          end
        end
      end
      default: state_d = SC_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SC_ISSUE;
      pos_q   <= '0;
      cnt_q   <= '0;
      bytes_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      cnt_q   <= cnt_d;
      bytes_q <= bytes_d;
      ovf_q   <= ovf_d;
    end
  end

  assign rom_rd   = (state_q == SC_ISSUE);
  assign rom_addr = pos_q;
  assign wr_idx   = cnt_q[IW-1:0];
  assign wr_off   = pos_q;
  assign count    = cnt_q;
  assign bytes    = bytes_q;
  assign done     = (state_q == SC_DONE);
  assign overflow = ovf_q;

  assert_rom_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |-> (rom_addr < AW'(ARRAY_WORDS)));
  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  assert_bytes_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(bytes_q));
  assert_count_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DIR_DEPTH));
  assert_ovf_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> (cnt_q == CW'(DIR_DEPTH)));
  assert_count_steps_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + CW'(1)));
endmodule

// File: rtl/pds_dir_store.sv
module pds_dir_store #(
  parameter int AW        = 12,
  parameter int DIR_DEPTH = 64,
  localparam int CW = $clog2(DIR_DEPTH + 1),
  localparam int IW = $clog2(DIR_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_off,
  input  logic          done_i,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] lk_id,
  output logic          lk_hit,
  output logic [AW-1:0] lk_off
);
  logic [AW-1:0] dir_q [DIR_DEPTH];
  logic          hit;

  always_ff @(posedge clk) begin
    if (wr_en) dir_q[wr_idx] <= wr_off;
  end

  assign hit = done_i && (lk_id < count_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_hit <= 1'b0;
      lk_off <= '0;
    end else begin
      lk_hit <= hit;
      lk_off <= hit ? dir_q[lk_id[IW-1:0]] : '0;
    end
  end

  assert_lookup_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> $past(done_i));
  assert_lookup_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ($past(lk_id) < $past(count_i)));
  assert_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_off == '0));
endmodule

// File: rtl/pkt_dir_scan.sv
module pkt_dir_scan #(
  parameter int WORD_W      = 32,
  parameter int ARRAY_WORDS = 2816,
  parameter int BYTE_LIMIT  = 11264,
  parameter int DIR_DEPTH   = 64,
  parameter int SIZE_LSB    = 8,
  parameter int SIZE_W      = 8,
  localparam int AW = $clog2(ARRAY_WORDS),
  localparam int BW = $clog2(BYTE_LIMIT + 4 * (1 << SIZE_W) + 1),
  localparam int CW = $clog2(DIR_DEPTH + 1),
  localparam int IW = $clog2(DIR_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              rom_rd_o,
  output logic [AW-1:0]     rom_addr_o,
  input  logic [WORD_W-1:0] rom_data_i,
  input  logic [CW-1:0]     lk_id_i,
  output logic              lk_hit_o,
  output logic [AW-1:0]     lk_off_o,
  output logic [CW-1:0]     pkt_count_o,
  output logic [BW-1:0]     byte_total_o,
  output logic              done_o,
  output logic              overflow_o
);
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [AW-1:0] wr_off;

  pds_walker #(
    .WORD_W(WORD_W), .ARRAY_WORDS(ARRAY_WORDS), .BYTE_LIMIT(BYTE_LIMIT),
    .DIR_DEPTH(DIR_DEPTH), .SIZE_LSB(SIZE_LSB), .SIZE_W(SIZE_W)
  ) walker_i (
    .clk(clk), .rst_n(rst_n),
    .rom_rd(rom_rd_o), .rom_addr(rom_addr_o), .rom_data(rom_data_i),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_off(wr_off),
    .count(pkt_count_o), .bytes(byte_total_o),
    .done(done_o), .overflow(overflow_o)
  );

  pds_dir_store #(.AW(AW), .DIR_DEPTH(DIR_DEPTH)) store_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_off(wr_off),
    .done_i(done_o), .count_i(pkt_count_o),
    .lk_id(lk_id_i), .lk_hit(lk_hit_o), .lk_off(lk_off_o)
  );
endmodule

// File: tb/pkt_dir_scan_tb_top.sv
`timescale 1ns/1ps
module pkt_dir_scan_tb_top;
  localparam int NW = 2816;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rom_rd;
  logic [11:0] rom_addr;
  logic [31:0] rom_q = '0;
  logic [6:0]  lk_id = '0;
  logic        lk_hit;
  logic [11:0] lk_off;
  logic [6:0]  pkt_count;
  logic [13:0] byte_total;
  logic        done, overflow;

  logic [31:0] mem [NW];
  int          n_chk = 0, n_bad = 0, bad_addr = 0;
  int          exp_n, exp_bytes, wp;
  int          exp_off [80];
  bit          finished = 0;

  always #5 clk = ~clk;

  pkt_dir_scan dut_i (
    .clk(clk), .rst_n(rst_n),
    .rom_rd_o(rom_rd), .rom_addr_o(rom_addr), .rom_data_i(rom_q),
    .lk_id_i(lk_id), .lk_hit_o(lk_hit), .lk_off_o(lk_off),
    .pkt_count_o(pkt_count), .byte_total_o(byte_total),
    .done_o(done), .overflow_o(overflow)
  );

  always @(posedge clk) begin
    if (rom_rd) rom_q <= (int'(rom_addr) < NW) ? mem[rom_addr] : 32'h0;
    if (rst_n && rom_rd && int'(rom_addr) >= NW) bad_addr <= bad_addr + 1;
  end

  task automatic chk(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < NW; i++) mem[i] = 32'hFFFF_00FF;
    exp_n = 0; exp_bytes = 0; wp = 0;
  endtask

  task automatic add_pkt(int sz);
    mem[wp] = {16'hC3A5, sz[7:0], 8'h5A};
    exp_off[exp_n] = wp;
    exp_n++;
    exp_bytes += 4 * (sz + 1);
    wp += sz + 2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; lk_id = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_done(string req);
    int k;
    k = 0;
    while (!done && k < 20000) begin
      @(negedge clk);
      k++;
    end
    chk("R11 done reached", int'(done), 1);
    chk("R10 lookup in finishing cycle", int'(lk_hit), 0);
    @(negedge clk);
    chk({req, " lookup one cycle after done"}, int'(lk_hit), (exp_n > 0) ? 1 : 0);
  endtask

  task automatic look(string req, int id, int hit, int off);
    lk_id = id[6:0];
    @(negedge clk);
    chk({req, " hit"}, int'(lk_hit), hit);
    chk({req, " offset"}, int'(lk_off), off);
  endtask

  // {id, hit, offset} for image A
  localparam logic [19:0] VEC [7] = '{
    {7'd0, 1'b1, 12'd0},   {7'd1, 1'b1, 12'd5},  {7'd2, 1'b1, 12'd8},
    {7'd3, 1'b1, 12'd20},  {7'd4, 1'b0, 12'd0},  {7'd63, 1'b0, 12'd0},
    {7'd100, 1'b0, 12'd0}
  };

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // Image A: sizes 3,1,10,255, zero header, then a stray packet (R5)
    clear_img();
    add_pkt(3); add_pkt(1); add_pkt(10); add_pkt(255);
    mem[wp] = 32'hFFFF_00FF;
    mem[wp + 2] = {16'h0, 8'd5, 8'h0};
    repeat (2) @(negedge clk);
    chk("R11 reset done", int'(done), 0);
    chk("R11 reset count", int'(pkt_count), 0);
    chk("R11 reset bytes", int'(byte_total), 0);
    chk("R11 reset overflow", int'(overflow), 0);
    chk("R11 reset hit", int'(lk_hit), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first read at word 0", int'(rom_addr), 0);
    chk("R10 early lookup", int'(lk_hit), 0);
    wait_done("R9");
    chk("R5 count stops at zero header", int'(pkt_count), 4);
    chk("R4 byte total", int'(byte_total), exp_bytes);
    chk("R2 junk bits ignored", int'(byte_total), 1092);
    foreach (VEC[i]) begin
      look("R3 R9 vector", int'(VEC[i][19:13]), int'(VEC[i][12]), int'(VEC[i][11:0]));
    end

    // Image B: 11 x 255 -> byte limit and array end together
    clear_img();
    for (int i = 0; i < 11; i++) add_pkt(255);
    do_reset();
    wait_done("R6");
    chk("R6 count at byte limit", int'(pkt_count), 11);
    chk("R6 byte total at limit", int'(byte_total), 11264);
    look("R1 last entry", 10, 1, 2570);
    look("R9 past count", 11, 0, 0);

    // Image C: 11 x 254 -> array end below byte limit
    clear_img();
    for (int i = 0; i < 11; i++) add_pkt(254);
    do_reset();
    wait_done("R7");
    chk("R7 count at array end", int'(pkt_count), 11);
    chk("R7 bytes below limit", int'(byte_total), 11220);
    look("R7 last entry", 10, 1, 2560);

    // Image D: 65 x size 1 -> directory full
    clear_img();
    for (int i = 0; i < 65; i++) add_pkt(1);
    do_reset();
    wait_done("R8");
    chk("R8 overflow set", int'(overflow), 1);
    chk("R8 count capped", int'(pkt_count), 64);
    chk("R8 bytes exclude extra", int'(byte_total), 512);
    look("R8 entry 63", 63, 1, exp_off[63]);
    look("R8 id 64 misses", 64, 0, 0);

    // Image E: first header zero; also clears overflow (R11)
    clear_img();
    do_reset();
    @(negedge clk);
    chk("R11 overflow cleared", int'(overflow), 0);
    wait_done("R5");
    chk("R5 empty count", int'(pkt_count), 0);
    chk("R5 empty bytes", int'(byte_total), 0);
    look("R9 empty lookup", 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R11 done held", int'(done), 1);
    chk("R7 no out-of-range read", bad_addr, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule